// File: doc/BRIEF.md
# Serial Transmitter with Fractional Bit Timing

This block turns bytes into asynchronous serial frames on a single output line. A byte is handed over on a valid/ready handshake. The block sends a low start bit, then the data bits least significant first. An optional parity bit follows, then one or two high stop bits. The line rests high between frames.

The frame shape comes from a packed line-configuration word. The bit duration comes from an integer divisor and a 3-bit fractional trim, both counted in cycles of the 24 MHz reference clock. The configuration ports are static inputs. They are captured when a byte is accepted, so changing them while a frame is on the line does not disturb that frame. Two status outputs, transmitter-empty and buffer-empty, show whether a frame is in progress.

A divisor of zero marks the line as unconfigured: the block then refuses bytes. A new byte can be accepted in the last cycle of the previous frame's final stop bit, so frames can follow each other with no idle gap.

Top module: `uart_txf_top`

## Requirements
- R1: After reset the line is high and both empty flags are 1; with a nonzero divisor the block is ready.
- R2: The number of data bits is line_cfg[1:0] + 5 (from 5 to 8), and they are sent least significant bit first, right after a start bit of 0.
- R3: When line_cfg[2] is 0 the frame ends with one stop bit of 1. When it is 1 the frame ends with two stop bits of 1.
- R4: When line_cfg[5] is 1, a parity bit follows the data bits. For line_cfg[5:3] = 3'b100 it makes the count of ones odd, and for 3'b101 it makes the count even. The value 3'b110 forces it to 1 and 3'b111 forces it to 0. When line_cfg[5] is 0 there is no parity bit.
- R5: Every bit lasts P clock cycles, where P = ((16 × baud_div) mod 65536) + baud_frac + 16.
- R6: While baud_div is 0, tx_ready is 0, no byte is accepted and the line stays high.
- R7: Both empty flags fall at the clock edge that accepts a byte, together with the start of the start bit. They rise, with the line returning high, exactly N × P cycles later, where N is the frame length in bits.
- R8: A byte offered during the last cycle of a frame is accepted at that frame's end. Its start bit then follows at once, and the empty flags stay 0.
- R9: line_cfg[6] has no effect on the frame.
- R10: The configuration and data are captured at the accepting edge; changes to them during a frame do not alter that frame.
- R11: The line is high whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cfg | input | 7 | Frame format: [1:0] data length, [2] stop bits, [5:3] parity mode, [6] ignored |
| baud_div | input | 16 | Integer bit-period divisor; 0 means unconfigured |
| baud_frac | input | 3 | Fractional bit-period trim in clock cycles |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be taken this cycle |
| tx_line | output | 1 | Serial output, idles high |
| xmit_empty | output | 1 | No frame in progress |
| buf_empty | output | 1 | No byte held for sending |

## Verification
Two events can fall in the same clock cycle: the end of one frame's final stop bit and the acceptance of the next byte. The bench provokes this by keeping tx_valid high through a whole frame with the following byte already on tx_data. It then checks that, at the cycle where the flags would otherwise rise, the line has dropped to a start bit and both flags are still low. The second frame must then match its own expected bit pattern for its full length.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  // Packed frame-format word; field order matches the line_cfg port bits.
  typedef struct packed {
    logic       ir_sel;    // [6] accepted, no effect
    logic [2:0] par_mode;  // [5:3] bit 5 enables parity
    logic       two_stop;  // [2]
    logic [1:0] len_sel;   // [1:0] data bits minus 5
  } line_cfg_t;

  localparam int BASE_LEN = 5;

endpackage

// File: rtl/uart_txf_frame.sv
module uart_txf_frame
  import uart_txf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  line_cfg_t           cfg,
  input  logic [DATA_W-1:0]   data,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_W-1:0]    nbits
);

  int   dlen;
  logic ones;
  logic pbit;
  logic par_en;
  logic unused_ir;

  assign unused_ir = cfg.ir_sel;

  always_comb begin
    dlen   = int'(cfg.len_sel) + BASE_LEN;
    par_en = cfg.par_mode[2];
    ones   = 1'b0;
    frame  = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dlen) begin
        frame[1+i] = data[i];
        ones       = ones ^ data[i];
      end
    end
    case (cfg.par_mode[1:0])
      2'b00:   pbit = ~ones;
      2'b01:   pbit = ones;
      2'b10:   pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    if (par_en) frame[1+dlen] = pbit;
    nbits = LEN_W'(1 + dlen + (par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1));
  end

endmodule

// File: rtl/uart_txf_baud.sv
module uart_txf_baud #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      per_q <= '0;
    end else if (load) begin
      per_q <= reload;
      cnt   <= reload - CNT_W'(1);
    end else if (run) begin
      if (cnt == '0) cnt <= per_q - CNT_W'(1);
      else           cnt <= cnt - CNT_W'(1);
    end
  end

  assign tick = run && (cnt == '0);

  // R5: the down-counter never leaves the captured period window
  assert_cnt_window_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < per_q));

endmodule

// File: rtl/uart_txf_shift.sv
module uart_txf_shift #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   nbits,
  input  logic               tick,
  output logic               tx_line,
  output logic               xmit_empty,
  output logic               buf_empty,
  output logic               busy,
  output logic               last
);

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      tx_line    <= 1'b1;
      xmit_empty <= 1'b1;
      buf_empty  <= 1'b1;
      shreg      <= '1;
      left       <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      tx_line    <= frame[0];
      shreg      <= {1'b1, frame[FRAME_W-1:1]};
      left       <= nbits;
      xmit_empty <= 1'b0;
      buf_empty  <= 1'b0;
    end else if (tick) begin
      if (left == LEN_W'(1)) begin
        busy       <= 1'b0;
        tx_line    <= 1'b1;
        xmit_empty <= 1'b1;
        buf_empty  <= 1'b1;
        left       <= '0;
      end else begin
        tx_line <= shreg[0];
        shreg   <= {1'b1, shreg[FRAME_W-1:1]};
        left    <= left - LEN_W'(1);
      end
    end
  end

  assign last = busy && tick && (left == LEN_W'(1));

  // R11: line rests high outside a frame
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);

  // R3: a frame always finishes on a high stop bit
  assert_stop_before_done_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(xmit_empty) |-> $past(tx_line));

  // R2: remaining bit count stays within one frame
  assert_left_bound_R2: assert property (@(posedge clk) disable iff (rst)
    left <= LEN_W'(FRAME_W));

endmodule

// File: rtl/uart_txf_top.sv
module uart_txf_top
  import uart_txf_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int FRAC_W   = 3,
  parameter int OVS_LOG2 = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        line_cfg,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [FRAC_W-1:0] baud_frac,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line,
  output logic              xmit_empty,
  output logic              buf_empty
);

  localparam int CNT_W   = DIV_W + 1;
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  line_cfg_t          cfg;
  logic [DIV_W-1:0]   scaled;
  logic [CNT_W-1:0]   reload;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   nbits;
  logic               cfg_ok;
  logic               accept;
  logic               busy;
  logic               last;
  logic               tick;

  assign cfg    = line_cfg_t'(line_cfg);
  assign scaled = baud_div << OVS_LOG2;
  assign reload = CNT_W'(scaled) + CNT_W'(baud_frac) + CNT_W'(1 << OVS_LOG2);
  assign cfg_ok = |baud_div;

  assign tx_ready = cfg_ok && (!busy || last);
  assign accept   = tx_valid && tx_ready;

  uart_txf_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_frame (
    .cfg   (cfg),
    .data  (tx_data),
    .frame (frame),
    .nbits (nbits)
  );

  uart_txf_baud #(.CNT_W(CNT_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .run    (busy),
    .reload (reload),
    .tick   (tick)
  );

  uart_txf_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .frame      (frame),
    .nbits      (nbits),
    .tick       (tick),
    .tx_line    (tx_line),
    .xmit_empty (xmit_empty),
    .buf_empty  (buf_empty),
    .busy       (busy),
    .last       (last)
  );

  // R7: an accepted byte starts the start bit and clears both flags
  assert_accept_start_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!tx_line && !xmit_empty && !buf_empty));

  // R6: an idle, unconfigured line never starts a frame
  assert_unconfig_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && baud_div == '0) |=> (!busy && tx_line));

endmodule

// File: tb/test_uart_txf_top.sv
module test_uart_txf_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] line_cfg = '0;
  logic [15:0] baud_div = 16'd1;
  logic [2:0] baud_frac = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line, xmit_empty, buf_empty;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  uart_txf_top i_uart_txf_top (
    .clk(clk), .rst(rst), .line_cfg(line_cfg), .baud_div(baud_div),
    .baud_frac(baud_frac), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_line(tx_line), .xmit_empty(xmit_empty),
    .buf_empty(buf_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [7:0] d, input logic [6:0] lc);
    logic [15:0] fr;
    logic ones;
    int dl;
    dl = int'(lc[1:0]) + 5;
    fr = '1;
    fr[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < dl; i++) begin
      fr[1+i] = d[i];
      ones = ones ^ d[i];
    end
    if (lc[5]) begin
      case (lc[4:3])
        2'b00:   fr[1+dl] = ~ones;
        2'b01:   fr[1+dl] = ones;
        2'b10:   fr[1+dl] = 1'b1;
        default: fr[1+dl] = 1'b0;
      endcase
    end
    return fr;
  endfunction

  function automatic int exp_nbits(input logic [6:0] lc);
    return 1 + int'(lc[1:0]) + 5 + (lc[5] ? 1 : 0) + (lc[2] ? 2 : 1);
  endfunction

  function automatic int exp_period(input logic [15:0] dv, input logic [2:0] fr);
    return int'((dv * 16'd16) & 16'hFFFF) + int'(fr) + 16;
  endfunction

  // Drive inputs at a falling edge, wait for ready, present one byte.
  task automatic launch(input logic [7:0] d, input logic [6:0] lc,
                        input logic [15:0] dv, input logic [2:0] fr, input bit hold);
    @(negedge clk);
    line_cfg = lc; baud_div = dv; baud_frac = fr; tx_data = d;
    #1;
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    @(negedge clk);
    if (!hold) tx_valid = 1'b0;
  endtask

  // Starts at the falling edge right after the accepting edge (j = 0).
  task automatic track(input logic [15:0] fr, input int n, input int p,
                       input bit nxt, input string req);
    int bad_line = 0, bad_flag = 0, first_j = -1;
    for (int j = 0; j <= n * p; j++) begin
      if (j < n * p) begin
        if (tx_line !== fr[j / p]) begin
          bad_line++;
          if (first_j < 0) first_j = j;
        end
        if (xmit_empty !== 1'b0 || buf_empty !== 1'b0) bad_flag++;
        @(negedge clk);
      end else begin
        if (nxt)
          chk(tx_line === 1'b0 && xmit_empty === 1'b0 && buf_empty === 1'b0,
              "R8 back-to-back start", {tx_line, xmit_empty, buf_empty}, 3'b000);
        else
          chk(tx_line === 1'b1 && xmit_empty === 1'b1 && buf_empty === 1'b1,
              "R7 R5 frame end", {tx_line, xmit_empty, buf_empty}, 3'b111);
      end
    end
    chk(bad_line == 0, {req, " line bits (first bad cycle in actual)"}, first_j, -1);
    chk(bad_flag == 0, "R7 flags low during frame", bad_flag, 0);
  endtask

  task automatic run_one(input logic [7:0] d, input logic [6:0] lc,
                         input logic [15:0] dv, input logic [2:0] fr,
                         input bit scramble, input string req);
    logic [15:0] f;
    int n, p;
    f = exp_frame(d, lc);
    n = exp_nbits(lc);
    p = exp_period(dv, fr);
    launch(d, lc, dv, fr, 1'b0);
    if (scramble) begin
      line_cfg = ~lc; baud_div = 16'd0; baud_frac = ~fr; tx_data = ~d;
    end
    track(f, n, p, 1'b0, req);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int idx;
    int bad;
    logic [2:0] pf;
    logic [6:0] lc;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx_line === 1'b1 && xmit_empty === 1'b1 && buf_empty === 1'b1 && tx_ready === 1'b1,
        "R1 reset state", {tx_line, xmit_empty, buf_empty, tx_ready}, 4'hF);

    // Sweep of lengths (R2), stop bits (R3), parity modes (R4), ignored bit 6 (R9),
    // fractional periods (R5), mid-frame config changes (R10), idle high (R11)
    idx = 0;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++)
        for (int pm = 0; pm < 6; pm++)
          for (int b = 0; b < 2; b++) begin
            case (pm)
              0: pf = 3'b000;
              1: pf = 3'b011;
              2: pf = 3'b100;
              3: pf = 3'b101;
              4: pf = 3'b110;
              default: pf = 3'b111;
            endcase
            lc = {1'(idx % 2), pf, 1'(s), 2'(l)};
            d  = 8'(idx * 53 + 17) ^ (b != 0 ? 8'hFF : 8'h00);
            run_one(d, lc, 16'd1, 3'(idx), 1'b1, "R2 R3 R4 R5 R9 R10 R11");
            chk(tx_line === 1'b1, "R11 idle high after frame", tx_line, 1);
            idx++;
          end

    // R5: larger divisor and a divisor whose scaled value wraps to zero
    run_one(8'h3C, 7'b0101011, 16'd2, 3'd7, 1'b0, "R5 divisor 2");
    run_one(8'hC3, 7'b0000011, 16'h1000, 3'd3, 1'b0, "R5 wrapped divisor");

    // R9: same byte with bit 6 set and clear must give identical frames
    run_one(8'h96, 7'b1100010, 16'd1, 3'd5, 1'b0, "R9 bit6 set");
    run_one(8'h96, 7'b0100010, 16'd1, 3'd5, 1'b0, "R9 bit6 clear");

    // R6: divisor zero refuses bytes and keeps the line idle
    @(negedge clk);
    baud_div = 16'd0; tx_data = 8'h00; tx_valid = 1'b1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tx_ready !== 1'b0 || tx_line !== 1'b1 || xmit_empty !== 1'b1 || buf_empty !== 1'b1) bad++;
    end
    chk(bad == 0, "R6 unconfigured divisor", bad, 0);
    tx_valid = 1'b0;

    // R8: byte offered across the frame end is taken with no gap
    begin
      logic [6:0] lc2;
      int n2, p2;
      lc2 = 7'b0110111;
      n2 = exp_nbits(lc2);
      p2 = exp_period(16'd1, 3'd2);
      launch(8'h5A, lc2, 16'd1, 3'd2, 1'b1);
      tx_data = 8'hE1;
      track(exp_frame(8'h5A, lc2), n2, p2, 1'b1, "R8 first frame");
      tx_valid = 1'b0;
      track(exp_frame(8'hE1, lc2), n2, p2, 1'b0, "R8 second frame");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule